// File: doc/BRIEF.md
# ADC Track-and-Convert Phase Sequencer

This block drives the phase control of a successive-approximation converter front end. It runs on the converter clock. A start pulse that arrives while the block is idle begins a sequence with three parts. First, a tracking phase holds the sampling switch closed for a programmed number of cycles. Next comes a conversion phase of fixed length. Last, a one-cycle done strobe marks the end. The tracking length is decoded from a 4-bit field and a 1-bit extension select, and both are captured when the start pulse is accepted.

All pins are plain control and status levels. The block carries no data stream, so there is no valid/ready handshake and no back-pressure. A start pulse that cannot be accepted is dropped without effect. The effective tracking count chosen for the current or most recent sequence is shown on an output so that software-facing logic can compute the sample period. That period is the tracking count plus 14.

Top module: `ats_seq_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns the block to idle, with `track_en`, `conv_busy` and `done` low and `trk_cycles` zero from the next cycle on. A sequence in progress is abandoned.
- R2: When `start` is high at an edge while the block is idle, `track_en` is high from the next cycle for exactly N consecutive cycles. From that same cycle `trk_cycles` equals N.
- R3: With `trk_ext` = 0, N = max(6, `trk_field` + 1). Field 0 gives 6 and field 15 gives 16.
- R4: With `trk_ext` = 1, N = max(6, 4 × (`trk_field` + 1) − 10). Fields 0 to 3 give 6, field 5 gives 14 and field 15 gives 54.
- R5: `conv_busy` is high for exactly 14 consecutive cycles, starting in the cycle right after the last tracking cycle.
- R6: `done` is high for exactly one cycle, the cycle after the last conversion cycle. The first tracking cycle and `done` are therefore N + 14 cycles apart.
- R7: `track_en` and `conv_busy` are never high in the same cycle.
- R8: `start` is ignored while `track_en`, `conv_busy` or `done` is high. The phase sequence runs on unchanged, and the cycle after `done` is idle.
- R9: `trk_field` and `trk_ext` are sampled only at an accepted start. Changing them during a sequence has no effect on that sequence's lengths or on `trk_cycles`.
- R10: N always lies between 6 and 54 inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start trigger, honoured only when idle |
| trk_field | input | 4 | Tracking-time field |
| trk_ext | input | 1 | Tracking extension select (scale by four with offset) |
| track_en | output | 1 | Sampling switch closed (tracking phase) |
| conv_busy | output | 1 | Conversion phase active |
| done | output | 1 | One-cycle end-of-sequence strobe |
| trk_cycles | output | 6 | Effective tracking cycle count latched at the last accepted start |

## Verification
The bench tests the edges of the decode. In extended mode, fields 0 to 3 must clamp to 6; a design that wraps the negative result would instead track for a huge or near-zero number of cycles. Fields 15 in both modes are also tested, where an off-by-one or a truncated counter would cut the 54-cycle maximum short. Start pulses and field changes are applied during tracking, during conversion and in the done cycle: a design that re-arms, or that reads the live field, would show a wrong phase length or a changed count. A reset is also applied in mid-tracking, and the bench checks that every output drops at once.

// File: rtl/ats_pkg.sv
package ats_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_TRACK = 2'd1,
    PH_CONV  = 2'd2,
    PH_DONE  = 2'd3
  } phase_e;
endpackage

// File: rtl/ats_track_decode.sv
module ats_track_decode #(
  parameter int FIELD_W    = 4,
  parameter int CNT_W      = 6,
  parameter int MIN_TRK    = 6,
  parameter int EXT_SCALE  = 4,
  parameter int EXT_OFFSET = 10
) (
  input  logic [FIELD_W-1:0] field,
  input  logic               ext,
  output logic [CNT_W-1:0]   cycles
);
  int raw;

  always_comb begin
    if (ext) raw = EXT_SCALE * (int'(field) + 1) - EXT_OFFSET;
    else     raw = int'(field) + 1;
    if (raw < MIN_TRK) raw = MIN_TRK;
    cycles = CNT_W'(raw);
  end
endmodule

// File: rtl/ats_phase_seq.sv
module ats_phase_seq
  import ats_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int CONV_CYC = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] trk_load,
  output logic             track_en,
  output logic             conv_busy,
  output logic             done,
  output logic [CNT_W-1:0] trk_cycles
);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] CONV_TOP = CNT_W'(CONV_CYC - 1);

  phase_e           phase;
  logic [CNT_W-1:0] remain;
  logic             last;

  assign last = (remain == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      remain     <= '0;
      trk_cycles <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase      <= PH_TRACK;
          remain     <= trk_load - ONE;
          trk_cycles <= trk_load;
        end
        PH_TRACK: if (last) begin
          phase  <= PH_CONV;
          remain <= CONV_TOP;
        end else begin
          remain <= remain - ONE;
        end
        PH_CONV: if (last) phase <= PH_DONE;
                 else      remain <= remain - ONE;
        PH_DONE: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign track_en  = (phase == PH_TRACK);
  assign conv_busy = (phase == PH_CONV);
  assign done      = (phase == PH_DONE);
endmodule

// File: rtl/ats_seq_top.sv
module ats_seq_top #(
  parameter int FIELD_W    = 4,
  parameter int MIN_TRK    = 6,
  parameter int EXT_SCALE  = 4,
  parameter int EXT_OFFSET = 10,
  parameter int CONV_CYC   = 14,
  localparam int MAX_TRK   = EXT_SCALE * (2 ** FIELD_W) - EXT_OFFSET,
  localparam int TOP_CNT   = (MAX_TRK > CONV_CYC) ? MAX_TRK : CONV_CYC,
  localparam int CNT_W     = $clog2(TOP_CNT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FIELD_W-1:0] trk_field,
  input  logic               trk_ext,
  output logic               track_en,
  output logic               conv_busy,
  output logic               done,
  output logic [CNT_W-1:0]   trk_cycles
);
  logic [CNT_W-1:0] trk_load;

  ats_track_decode #(
    .FIELD_W(FIELD_W), .CNT_W(CNT_W), .MIN_TRK(MIN_TRK),
    .EXT_SCALE(EXT_SCALE), .EXT_OFFSET(EXT_OFFSET)
  ) u_decode (
    .field (trk_field),
    .ext   (trk_ext),
    .cycles(trk_load)
  );

  ats_phase_seq #(.CNT_W(CNT_W), .CONV_CYC(CONV_CYC)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .trk_load  (trk_load),
    .track_en  (track_en),
    .conv_busy (conv_busy),
    .done      (done),
    .trk_cycles(trk_cycles)
  );
endmodule

// File: rtl/ats_seq_checker.sv
module ats_seq_checker #(
  parameter int CNT_W    = 6,
  parameter int MIN_TRK  = 6,
  parameter int MAX_TRK  = 54,
  parameter int CONV_CYC = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             track_en,
  input logic             conv_busy,
  input logic             done,
  input logic [CNT_W-1:0] trk_cycles
);
  logic [CNT_W:0] trk_run;
  logic [CNT_W:0] conv_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      trk_run  <= '0;
      conv_run <= '0;
    end else begin
      trk_run  <= track_en  ? trk_run + 1'b1  : '0;
      conv_run <= conv_busy ? conv_run + 1'b1 : '0;
    end
  end

  a_r7_mutex: assert property (@(posedge clk) disable iff (rst)
    !(track_en && conv_busy));

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_done_after_conv: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(conv_busy));

  a_r5_conv_len: assert property (@(posedge clk) disable iff (rst)
    done |-> (conv_run == (CNT_W+1)'(CONV_CYC)));

  a_r2_track_len: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_busy) |-> (trk_run == {1'b0, trk_cycles}));

  a_r10_range: assert property (@(posedge clk) disable iff (rst)
    track_en |-> (trk_cycles >= CNT_W'(MIN_TRK) && trk_cycles <= CNT_W'(MAX_TRK)));

  a_r9_stable: assert property (@(posedge clk) disable iff (rst)
    (track_en || conv_busy) |=> $stable(trk_cycles));

  a_r8_conv_hold: assert property (@(posedge clk) disable iff (rst)
    conv_busy |=> (conv_busy || done));

  a_r8_track_hold: assert property (@(posedge clk) disable iff (rst)
    track_en |=> (track_en || conv_busy));

  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |=> !track_en);
endmodule

bind ats_seq_top ats_seq_checker #(
  .CNT_W(CNT_W), .MIN_TRK(MIN_TRK), .MAX_TRK(MAX_TRK), .CONV_CYC(CONV_CYC)
) u_checker (
  .clk       (clk),
  .rst       (rst),
  .track_en  (track_en),
  .conv_busy (conv_busy),
  .done      (done),
  .trk_cycles(trk_cycles)
);

// File: tb/ats_seq_top_tb_top.sv
module ats_seq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CONV_LEN   = 14;

  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic [3:0] trk_field;
  logic       trk_ext;
  logic       track_en, conv_busy, done;
  logic [5:0] trk_cycles;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ats_seq_top dut_i (
    .clk(clk), .rst(rst), .start(start), .trk_field(trk_field), .trk_ext(trk_ext),
    .track_en(track_en), .conv_busy(conv_busy), .done(done), .trk_cycles(trk_cycles)
  );

  function automatic int exp_track(input int f, input bit e);
    int v;
    v = e ? (4 * f + 4 - 10) : (f + 1);
    return (v < 6) ? 6 : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  // One full sequence; disturb=1 toggles start and settings while busy.
  task automatic run_seq(input int f, input bit e, input bit disturb);
    int n, tcnt, ccnt;
    n = exp_track(f, e);
    @(negedge clk);
    trk_field = 4'(f); trk_ext = e; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(track_en == 1'b1, "R2 track starts", int'(track_en), 1);
    chk(int'(trk_cycles) == n, (e ? "R4 decode" : "R3 decode"), int'(trk_cycles), n);
    chk(n >= 6 && int'(trk_cycles) <= 54, "R10 range", int'(trk_cycles), n);
    tcnt = 0;
    while (track_en && tcnt < 100) begin
      if (conv_busy) chk(1'b0, "R7 overlap", 1, 0);
      tcnt++;
      if (disturb) begin
        start = 1'($urandom_range(0, 1));
        trk_field = 4'($urandom_range(0, 15)); trk_ext = 1'($urandom_range(0, 1));
      end
      @(negedge clk);
    end
    chk(tcnt == n, "R2 track length", tcnt, n);
    chk(conv_busy == 1'b1, "R5 conv follows track", int'(conv_busy), 1);
    ccnt = 0;
    while (conv_busy && ccnt < 100) begin
      if (track_en) chk(1'b0, "R7 overlap", 1, 0);
      ccnt++;
      if (disturb) begin
        start = 1'($urandom_range(0, 1));
        trk_field = 4'($urandom_range(0, 15)); trk_ext = 1'($urandom_range(0, 1));
      end
      @(negedge clk);
    end
    chk(ccnt == CONV_LEN, "R5 conv length", ccnt, CONV_LEN);
    chk(done == 1'b1, "R6 done after conv", int'(done), 1);
    chk(int'(trk_cycles) == n, "R9 count held", int'(trk_cycles), n);
    start = disturb;  // start in the done cycle must be ignored
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R6 done single", int'(done), 0);
    chk(track_en == 1'b0 && conv_busy == 1'b0, "R8 idle after done",
        int'(track_en) + int'(conv_busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; start = 1'b0; trk_field = 4'd0; trk_ext = 1'b0;
    repeat (3) @(negedge clk);
    chk({track_en, conv_busy, done} == 3'b000 && trk_cycles == 6'd0, "R1 reset state",
        int'({track_en, conv_busy, done, trk_cycles}), 0);
    rst = 1'b0;

    run_seq(0, 1'b0, 1'b0);   // R3 floor
    run_seq(15, 1'b0, 1'b0);  // R3 top
    run_seq(4, 1'b0, 1'b0);
    for (int f = 0; f < 6; f++) run_seq(f, 1'b1, 1'b0);  // R4 clamp and 14
    run_seq(15, 1'b1, 1'b0);  // R4 max 54
    run_seq(15, 1'b1, 1'b1);  // R8 R9 disturbed at max

    // R1: reset in mid-tracking
    @(negedge clk);
    trk_field = 4'd9; trk_ext = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk({track_en, conv_busy, done} == 3'b000 && trk_cycles == 6'd0, "R1 mid-run reset",
        int'({track_en, conv_busy, done, trk_cycles}), 0);

    for (int i = 0; i < 40; i++)
      run_seq(int'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

    finish_run();
  end
endmodule